// File: doc/BRIEF.md
# Subroutine and Interrupt Return Stack

This block is the hardware return stack of a small 4-bit processor core. Each subroutine call or interrupt entry pushes one record onto it: the address to resume at, plus the carry flag as it stood at the time. A return pops the newest record. The core uses the popped address as its next program counter.

There are two kinds of return. An interrupt-style return also hands back the saved carry. A table-style return hands back only the address and leaves the core's live carry as it is. When the stack already holds its full count of records, a further push is still accepted, and the oldest record is silently lost. Nesting too deeply therefore never stalls the core.

A pop from an empty stack is answered with address 0 and the live carry, together with a one-cycle underflow pulse. A push and a pop in the same cycle replace the top record: the old top is returned and the new one takes its place. All results appear on registered outputs one clock after the strobe. The current number of held records is also exposed.

Top module: `ret_stack`

## Requirements
- R1: After synchronous reset the stack holds no records: `depth_o` is 0, and `ret_valid_o` and `underflow_o` are 0.
- R2: A push without a pop stores `{carry_i, pc_i}` as the new top record. `depth_o` rises by one on the next cycle unless it is already DEPTH.
- R3: Records come back last-in, first-out. A pop of a non-empty stack drives `ret_pc_o` with the most recently pushed address still held. This value appears in the cycle after the pop strobe.
- R4: When `ret_kind_i` is 0 (restore), `ret_carry_o` of a non-empty pop equals the carry saved in the popped record.
- R5: When `ret_kind_i` is 1 (keep), `ret_carry_o` equals the `carry_i` value sampled with the pop strobe, whatever carry the record holds.
- R6: A push when DEPTH records are held drops the oldest record and keeps the new one. `depth_o` stays at DEPTH. After that, DEPTH pops return the DEPTH newest addresses, newest first.
- R7: A pop of an empty stack yields `ret_pc_o` = 0 and `ret_carry_o` = sampled `carry_i`. `underflow_o` is high for exactly that one result cycle, and `depth_o` stays 0.
- R8: A push and a pop in the same cycle on a non-empty stack return the old top record and put the new record in its place, with `depth_o` unchanged. On an empty stack the same pair reports an underflow and leaves one record.
- R9: `ret_valid_o` is high in exactly the cycle after each pop strobe and low otherwise. When it is low, `ret_pc_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| push_i | input | 1 | Push strobe (call or interrupt entry) |
| pop_i | input | 1 | Pop strobe (return) |
| ret_kind_i | input | 1 | Return kind: 0 restores the saved carry, 1 keeps the live carry |
| pc_i | input | PC_W | Address to save on push |
| carry_i | input | 1 | Live carry flag, saved on push and passed through on a keep-carry pop |
| ret_valid_o | output | 1 | Pop result valid |
| ret_pc_o | output | PC_W | Popped return address |
| ret_carry_o | output | 1 | Carry flag after the return |
| underflow_o | output | 1 | One-cycle pulse: pop of an empty stack |
| depth_o | output | $clog2(DEPTH+1) | Number of records held |

## Verification
The bench builds the block with DEPTH = 8 and PC_W = 12. Eight levels is small enough that runs of overflow pushes carry the circular top pointer around the storage several times, which shows that the discarded record is always the oldest one. Full 12-bit addresses with random carries separate the two carry sources, so a return of the wrong kind shows up as a carry mismatch. A long random mix of push, pop and combined strobes, skewed so the stack swings between empty and full, reaches underflow, overflow and replace-top on every pointer position.

// File: rtl/ret_stack_pkg.sv
package ret_stack_pkg;

  // Which carry a return hands back
  typedef enum logic {
    RET_RESTORE = 1'b0,
    RET_KEEP    = 1'b1
  } ret_kind_e;

  // Stack operation decoded from the two strobes
  typedef enum logic [1:0] {
    OP_IDLE = 2'd0,
    OP_PUSH = 2'd1,
    OP_POP  = 2'd2,
    OP_SWAP = 2'd3
  } stk_op_e;

  function automatic stk_op_e decode_op(input logic psh, input logic pp);
    stk_op_e op;
    unique case ({psh, pp})
      2'b10:   op = OP_PUSH;
      2'b01:   op = OP_POP;
      2'b11:   op = OP_SWAP;
      default: op = OP_IDLE;
    endcase
    return op;
  endfunction

endpackage

// File: rtl/ret_stack_ctrl.sv
module ret_stack_ctrl
  import ret_stack_pkg::*;
#(
  parameter int DEPTH = 8
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push_i,
  input  logic                       pop_i,
  output logic                       wr_en_o,
  output logic [$clog2(DEPTH)-1:0]   wr_addr_o,
  output logic                       rd_en_o,
  output logic [$clog2(DEPTH)-1:0]   rd_addr_o,
  output logic                       empty_pop_o,
  output logic [$clog2(DEPTH+1)-1:0] level_o
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);
  localparam bit   POW2 = ((DEPTH & (DEPTH - 1)) == 0);

  logic [PTR_W-1:0] top_q, top_d, up_ptr, dn_ptr;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             empty;
  stk_op_e          op;

  // Neighbouring slots of the top pointer, wrapping around the storage
  generate
    if (POW2) begin : g_wrap_free
      assign up_ptr = top_q + 1'b1;
      assign dn_ptr = top_q - 1'b1;
    end else begin : g_wrap_cmp
      assign up_ptr = (top_q == LAST) ? '0 : top_q + 1'b1;
      assign dn_ptr = (top_q == '0) ? LAST : top_q - 1'b1;
    end
  endgenerate

  assign op    = decode_op(push_i, pop_i);
  assign empty = (cnt_q == '0);

  always_comb begin
    wr_en_o     = 1'b0;
    wr_addr_o   = up_ptr;
    rd_en_o     = 1'b0;
    empty_pop_o = 1'b0;
    top_d       = top_q;
    cnt_d       = cnt_q;
    unique case (op)
      OP_PUSH: begin
        // A full stack overwrites its oldest slot: the count saturates
        wr_en_o = 1'b1;
        top_d   = up_ptr;
        if (cnt_q != FULL) cnt_d = cnt_q + 1'b1;
      end
      OP_POP: begin
        if (empty) begin
          empty_pop_o = 1'b1;
        end else begin
          rd_en_o = 1'b1;
          top_d   = dn_ptr;
          cnt_d   = cnt_q - 1'b1;
        end
      end
      OP_SWAP: begin
        if (empty) begin
          empty_pop_o = 1'b1;
          wr_en_o     = 1'b1;
          top_d       = up_ptr;
          cnt_d       = CNT_W'(1);
        end else begin
          // Read-first storage returns the old top while it is replaced
          rd_en_o   = 1'b1;
          wr_en_o   = 1'b1;
          wr_addr_o = top_q;
        end
      end
      default: ;
    endcase
  end

  assign rd_addr_o = top_q;
  assign level_o   = cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      top_q <= LAST;
      cnt_q <= '0;
    end else begin
      top_q <= top_d;
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/ret_stack_store.sv
module ret_stack_store #(
  parameter int DEPTH = 8,
  parameter int W     = 13
) (
  input  logic                     clk,
  input  logic                     wr_en_i,
  input  logic [$clog2(DEPTH)-1:0] wr_addr_i,
  input  logic [W-1:0]             wr_data_i,
  input  logic                     rd_en_i,
  input  logic [$clog2(DEPTH)-1:0] rd_addr_i,
  output logic [W-1:0]             rd_data_o
);

  // Simple dual-port array with a registered, read-first read port
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en_i) mem[wr_addr_i] <= wr_data_i;
  end

  always_ff @(posedge clk) begin
    if (rd_en_i) rd_data_o <= mem[rd_addr_i];
  end

endmodule

// File: rtl/ret_stack_out.sv
module ret_stack_out
  import ret_stack_pkg::*;
#(
  parameter int PC_W = 12
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            pop_i,
  input  logic            empty_pop_i,
  input  ret_kind_e       kind_i,
  input  logic            carry_i,
  input  logic [PC_W:0]   entry_i,
  output logic            ret_valid_o,
  output logic [PC_W-1:0] ret_pc_o,
  output logic            ret_carry_o,
  output logic            underflow_o
);

  logic vld_q, uf_q, keep_q, cin_q;
  logic hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_q  <= 1'b0;
      uf_q   <= 1'b0;
      keep_q <= 1'b0;
      cin_q  <= 1'b0;
    end else begin
      vld_q  <= pop_i;
      uf_q   <= empty_pop_i;
      keep_q <= (kind_i == RET_KEEP);
      cin_q  <= carry_i;
    end
  end

  // The record register is not reset; it is only looked at after a real read
  assign hit         = vld_q && !uf_q;
  assign ret_valid_o = vld_q;
  assign underflow_o = uf_q;
  assign ret_pc_o    = hit ? entry_i[PC_W-1:0] : '0;
  assign ret_carry_o = (hit && !keep_q) ? entry_i[PC_W] : cin_q;

endmodule

// File: rtl/ret_stack.sv
module ret_stack
  import ret_stack_pkg::*;
#(
  parameter int DEPTH = 8,
  parameter int PC_W  = 12
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       push_i,
  input  logic                       pop_i,
  input  logic                       ret_kind_i,
  input  logic [PC_W-1:0]            pc_i,
  input  logic                       carry_i,
  output logic                       ret_valid_o,
  output logic [PC_W-1:0]            ret_pc_o,
  output logic                       ret_carry_o,
  output logic                       underflow_o,
  output logic [$clog2(DEPTH+1)-1:0] depth_o
);

  localparam int PTR_W = $clog2(DEPTH);
  localparam int REC_W = PC_W + 1;

  logic             wr_en, rd_en, empty_pop;
  logic [PTR_W-1:0] wr_addr, rd_addr;
  logic [REC_W-1:0] rd_data;
  ret_kind_e        kind;

  assign kind = ret_kind_e'(ret_kind_i);

  ret_stack_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .push_i      (push_i),
    .pop_i       (pop_i),
    .wr_en_o     (wr_en),
    .wr_addr_o   (wr_addr),
    .rd_en_o     (rd_en),
    .rd_addr_o   (rd_addr),
    .empty_pop_o (empty_pop),
    .level_o     (depth_o)
  );

  ret_stack_store #(.DEPTH(DEPTH), .W(REC_W)) u_store (
    .clk       (clk),
    .wr_en_i   (wr_en),
    .wr_addr_i (wr_addr),
    .wr_data_i ({carry_i, pc_i}),
    .rd_en_i   (rd_en),
    .rd_addr_i (rd_addr),
    .rd_data_o (rd_data)
  );

  ret_stack_out #(.PC_W(PC_W)) u_out (
    .clk         (clk),
    .rst         (rst),
    .pop_i       (pop_i),
    .empty_pop_i (empty_pop),
    .kind_i      (kind),
    .carry_i     (carry_i),
    .entry_i     (rd_data),
    .ret_valid_o (ret_valid_o),
    .ret_pc_o    (ret_pc_o),
    .ret_carry_o (ret_carry_o),
    .underflow_o (underflow_o)
  );

endmodule

// File: rtl/ret_stack_chk.sv
module ret_stack_chk #(
  parameter int DEPTH = 8,
  parameter int PC_W  = 12
) (
  input logic                       clk,
  input logic                       rst,
  input logic                       push_i,
  input logic                       pop_i,
  input logic                       ret_kind_i,
  input logic [PC_W-1:0]            pc_i,
  input logic                       carry_i,
  input logic                       ret_valid_o,
  input logic [PC_W-1:0]            ret_pc_o,
  input logic                       ret_carry_o,
  input logic                       underflow_o,
  input logic [$clog2(DEPTH+1)-1:0] depth_o
);

  // R2
  depth_up_chk: assert property (@(posedge clk) disable iff (rst)
    (push_i && !pop_i && depth_o < DEPTH) |=> (depth_o == $past(depth_o) + 1'b1));

  // R6
  depth_sat_chk: assert property (@(posedge clk) disable iff (rst)
    (push_i && !pop_i && depth_o == DEPTH) |=> (depth_o == DEPTH));

  // R3
  lifo_pair_chk: assert property (@(posedge clk) disable iff (rst)
    (push_i && !pop_i ##1 pop_i && !push_i) |=> (ret_pc_o == $past(pc_i, 2)));

  // R4
  restore_cy_chk: assert property (@(posedge clk) disable iff (rst)
    (push_i && !pop_i ##1 pop_i && !push_i && !ret_kind_i) |=> (ret_carry_o == $past(carry_i, 2)));

  // R5
  keep_cy_chk: assert property (@(posedge clk) disable iff (rst)
    (pop_i && ret_kind_i) |=> (ret_carry_o == $past(carry_i)));

  // R7
  empty_pop_chk: assert property (@(posedge clk) disable iff (rst)
    (pop_i && !push_i && depth_o == 0) |=> (underflow_o && ret_pc_o == '0 && depth_o == 0));

  // R7
  uf_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    underflow_o |-> ret_valid_o);

  // R8
  swap_depth_chk: assert property (@(posedge clk) disable iff (rst)
    (push_i && pop_i && depth_o != 0) |=> $stable(depth_o));

  // R9
  valid_follow_chk: assert property (@(posedge clk) disable iff (rst)
    pop_i |=> ret_valid_o);

  // R9
  valid_quiet_chk: assert property (@(posedge clk) disable iff (rst)
    !pop_i |=> (!ret_valid_o && !underflow_o && ret_pc_o == '0));

endmodule

bind ret_stack ret_stack_chk #(.DEPTH(DEPTH), .PC_W(PC_W)) u_chk (.*);

// File: tb/ret_stack_bench.sv
module ret_stack_bench;

  localparam int CLK_PERIOD = 10;
  localparam int DEPTH      = 8;
  localparam int PC_W       = 12;
  localparam int CNT_W      = $clog2(DEPTH + 1);

  logic             clk = 1'b0;
  logic             rst;
  logic             push_i, pop_i, ret_kind_i, carry_i;
  logic [PC_W-1:0]  pc_i;
  logic             ret_valid_o, ret_carry_o, underflow_o;
  logic [PC_W-1:0]  ret_pc_o;
  logic [CNT_W-1:0] depth_o;

  int checks = 0;
  int fails  = 0;
  int unsigned seed = 32'h1234_5678;

  logic [PC_W:0] model [$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  ret_stack #(.DEPTH(DEPTH), .PC_W(PC_W)) u_ret_stack (
    .clk         (clk),
    .rst         (rst),
    .push_i      (push_i),
    .pop_i       (pop_i),
    .ret_kind_i  (ret_kind_i),
    .pc_i        (pc_i),
    .carry_i     (carry_i),
    .ret_valid_o (ret_valid_o),
    .ret_pc_o    (ret_pc_o),
    .ret_carry_o (ret_carry_o),
    .underflow_o (underflow_o),
    .depth_o     (depth_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int unsigned rnd();
    seed = seed * 32'd1664525 + 32'd1013904223;
    return seed >> 8;
  endfunction

  // One clock: inputs driven at the falling edge, outputs compared at the next one
  task automatic step(input bit psh, input bit pp, input bit keep,
                      input logic [PC_W-1:0] pc, input bit cy);
    bit            e_uf, was_empty, was_full;
    logic [PC_W:0] rec;
    int            e_pc;
    bit            e_cy;
    push_i = psh; pop_i = pp; ret_kind_i = keep; pc_i = pc; carry_i = cy;
    was_empty = (model.size() == 0);
    was_full  = (model.size() == DEPTH);
    e_uf = 1'b0; e_pc = 0; e_cy = cy;
    if (pp) begin
      if (was_empty) e_uf = 1'b1;
      else begin
        rec  = model.pop_back();
        e_pc = int'(rec[PC_W-1:0]);
        if (!keep) e_cy = rec[PC_W];
      end
    end
    if (psh) begin
      model.push_back({cy, pc});
      if (model.size() > DEPTH) void'(model.pop_front());
    end
    @(posedge clk);
    @(negedge clk);
    check(ret_valid_o == pp, "R9", "ret_valid_o", int'(ret_valid_o), int'(pp));
    check(underflow_o == e_uf, "R7", "underflow_o", int'(underflow_o), int'(e_uf));
    if (pp) begin
      check(ret_pc_o == e_pc, (psh ? "R8" : (e_uf ? "R7" : "R3")), "ret_pc_o",
            int'(ret_pc_o), e_pc);
      check(ret_carry_o == e_cy, (keep ? "R5" : (e_uf ? "R7" : "R4")), "ret_carry_o",
            int'(ret_carry_o), int'(e_cy));
    end else begin
      check(ret_pc_o == 0, "R9", "idle ret_pc_o", int'(ret_pc_o), 0);
    end
    check(depth_o == model.size(),
          (psh && pp ? "R8" : (psh && was_full ? "R6" : "R2")), "depth_o",
          int'(depth_o), model.size());
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual running expected finished");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst = 1'b1; push_i = 0; pop_i = 0; ret_kind_i = 0; pc_i = '0; carry_i = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    // R1: reset state
    check(depth_o == 0, "R1", "depth_o", int'(depth_o), 0);
    check(ret_valid_o == 0, "R1", "ret_valid_o", int'(ret_valid_o), 0);
    check(underflow_o == 0, "R1", "underflow_o", int'(underflow_o), 0);

    // R7: pops on an empty stack, both kinds
    step(0, 1, 0, 12'h000, 1);
    step(0, 1, 1, 12'h000, 0);

    // R2, R3, R4, R5: three calls, then returns of both kinds
    step(1, 0, 0, 12'h123, 1);
    step(1, 0, 0, 12'hABC, 0);
    step(1, 0, 0, 12'hFFF, 1);
    step(0, 1, 0, 12'h000, 0);   // restore carry 1
    step(0, 1, 1, 12'h000, 1);   // keep live carry 1, record holds 0
    step(0, 1, 1, 12'h000, 0);   // keep live carry 0, record holds 1
    step(0, 1, 0, 12'h000, 1);   // now empty

    // R6: overflow by three, then drain past empty
    for (int i = 0; i < DEPTH + 3; i++)
      step(1, 0, 0, PC_W'(12'h100 + i), i[0]);
    for (int i = 0; i < DEPTH + 1; i++)
      step(0, 1, 0, 12'h000, 0);

    // R8: replace top, both on a held stack and on an empty one
    step(1, 0, 0, 12'h055, 0);
    step(1, 1, 0, 12'h0AA, 1);
    step(0, 1, 0, 12'h000, 0);
    step(1, 1, 1, 12'h777, 1);
    step(0, 1, 0, 12'h000, 0);

    // Random mix across every pointer position
    for (int i = 0; i < 3000; i++) begin
      int unsigned r = rnd();
      bit psh, pp;
      if ((i / 200) % 2 == 0) begin
        psh = (r % 10) < 6; pp = ((r >> 4) % 10) < 4;
      end else begin
        psh = (r % 10) < 4; pp = ((r >> 4) % 10) < 6;
      end
      step(psh, pp, r[9], PC_W'(r >> 12), r[10]);
    end

    step(0, 0, 0, 12'h000, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule